// File: doc/BRIEF.md
# Secure-Priority Random Word Distributor

This block sits after an entropy conditioning stage. It takes 32-bit random words from a valid/ready stream and places each accepted word into one of two buffers. The protected buffer serves secure-world consumers and holds eight words. The shared buffer serves non-secure consumers and holds four words. The routing policy keeps the protected buffer stocked before anything else. The shared buffer only receives words when the protected side has at least half its capacity in reserve, so heavy non-secure demand cannot starve secure readers.

Each buffer has its own read port. A one-cycle request pops the oldest word, and the word comes back with a valid strobe on the following cycle. Each buffer also reports its current word count. Between the two limits of the protected buffer (half full and completely full), words alternate between the two sides. Once either side is full, the other side takes every word. When both sides are full, the input stream is stalled.

Top module: `rng_secure_split`

## Requirements
- R1: After a synchronous reset both word counts are 0, both read-valid outputs are low and `in_ready` is high.
- R2: While the protected count is below half its depth (below 4 words), every accepted word is written to the protected buffer and the shared count does not change.
- R3: A word is written to the shared buffer only in a cycle where the protected count is at least half its depth (4 words or more).
- R4: While the protected count is at least 4 and below 8, and the shared buffer is not full, accepted words alternate between the two buffers. The first such word after reset goes to the shared buffer.
- R5: When the shared buffer is full and the protected buffer is not, words go to the protected buffer. When the protected buffer is full and the shared buffer is not, words go to the shared buffer.
- R6: With both buffers full, `in_ready` is low and an offered word changes neither count.
- R7: Each accepted word is written to exactly one buffer, so the sum of the two counts rises by exactly one per accepted word when no read occurs.
- R8: A read request to an empty buffer gives a low read-valid on the next cycle and leaves that buffer's count unchanged.
- R9: A read request to a non-empty buffer gives, on the next cycle, read-valid high with the oldest stored word of that buffer, and lowers its count by one.
- R10: A read and a write to the same buffer in one cycle are both performed: the count is unchanged, the oldest word is returned and the new word is kept.
- R11: A reset in the middle of operation empties both buffers and restores the alternation so that the next shared-region word goes to the shared buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Entropy word offered |
| in_data | input | 32 | Entropy word |
| in_ready | output | 1 | Word can be accepted this cycle |
| sec_req | input | 1 | Pop request, protected buffer |
| sec_valid | output | 1 | Protected read data valid (one cycle after request) |
| sec_data | output | 32 | Protected read data |
| sec_count | output | 4 | Words held in protected buffer (0 to 8) |
| pub_req | input | 1 | Pop request, shared buffer |
| pub_valid | output | 1 | Shared read data valid (one cycle after request) |
| pub_data | output | 32 | Shared read data |
| pub_count | output | 3 | Words held in shared buffer (0 to 4) |

## Verification
A wrong routing decision shows on the count outputs in the cycle right after the word is accepted. A word that lands on the wrong side, or on both sides, changes the wrong count or both counts at once. A stale alternation state only shows up later, when a buffer drains and a word from the wrong position appears on the read data. For that reason, every word carries a unique tag and both buffers are fully drained and compared against the expected order. A corrupted pointer or count appears one cycle after a read request, as a wrong word, a missing valid strobe, or a count that does not step by one.

// File: rtl/rng_split_pkg.sv
package rng_split_pkg;
    localparam int WORD_W = 32;

    // which side receives the next word inside the sharing window
    typedef enum logic {
        TURN_PUB = 1'b0,
        TURN_SEC = 1'b1
    } turn_e;

    typedef struct packed {
        turn_e turn;
    } route_state_t;
endpackage

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             out_valid;
        logic [WIDTH-1:0] out_data;
    } fifo_state_t;

    fifo_state_t      st_d, st_q;
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             push, pop;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_P) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        pop   = rd_req && (st_q.count != '0);
        push  = wr_en && (st_q.count != FULL_C);

        if (push) begin
            mem_d[st_q.wr_ptr] = wr_data;
            st_d.wr_ptr        = step_ptr(st_q.wr_ptr);
        end

        st_d.out_valid = pop;
        if (pop) begin
            st_d.out_data = mem_q[st_q.rd_ptr];
            st_d.rd_ptr   = step_ptr(st_q.rd_ptr);
        end

        unique case ({push, pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_valid = st_q.out_valid;
    assign rd_data  = st_q.out_data;
    assign count    = st_q.count;
endmodule

// File: rtl/rng_route_sel.sv
module rng_route_sel
    import rng_split_pkg::*;
#(
    parameter int SEC_DEPTH = 8,
    parameter int PUB_DEPTH = 4,
    localparam int SEC_CNT_W = $clog2(SEC_DEPTH + 1),
    localparam int PUB_CNT_W = $clog2(PUB_DEPTH + 1)
) (
    input  logic [SEC_CNT_W-1:0] sec_count,
    input  logic [PUB_CNT_W-1:0] pub_count,
    input  turn_e                turn,
    output logic                 can_take,
    output logic                 pick_pub,
    output logic                 sharing
);
    localparam logic [SEC_CNT_W-1:0] SEC_HALF_C = SEC_CNT_W'(SEC_DEPTH / 2);
    localparam logic [SEC_CNT_W-1:0] SEC_FULL_C = SEC_CNT_W'(SEC_DEPTH);
    localparam logic [PUB_CNT_W-1:0] PUB_FULL_C = PUB_CNT_W'(PUB_DEPTH);

    logic sec_low, sec_full, pub_full;

    always_comb begin
        sec_low  = sec_count < SEC_HALF_C;
        sec_full = sec_count == SEC_FULL_C;
        pub_full = pub_count == PUB_FULL_C;
        sharing  = !sec_low && !sec_full && !pub_full;
        can_take = !(sec_full && pub_full);

        if (sec_low)      pick_pub = 1'b0;
        else if (sharing) pick_pub = (turn == TURN_PUB);
        else              pick_pub = sec_full;
    end
endmodule

// File: rtl/rng_secure_split.sv
module rng_secure_split
    import rng_split_pkg::*;
#(
    parameter int SEC_DEPTH = 8,
    parameter int PUB_DEPTH = 4,
    localparam int SEC_CNT_W = $clog2(SEC_DEPTH + 1),
    localparam int PUB_CNT_W = $clog2(PUB_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    in_data,
    output logic                 in_ready,
    input  logic                 sec_req,
    output logic                 sec_valid,
    output logic [WORD_W-1:0]    sec_data,
    output logic [SEC_CNT_W-1:0] sec_count,
    input  logic                 pub_req,
    output logic                 pub_valid,
    output logic [WORD_W-1:0]    pub_data,
    output logic [PUB_CNT_W-1:0] pub_count
);
    route_state_t st_d, st_q;
    logic can_take, pick_pub, sharing, accept, wr_sec, wr_pub;

    rng_route_sel #(
        .SEC_DEPTH(SEC_DEPTH),
        .PUB_DEPTH(PUB_DEPTH)
    ) u_sel (
        .sec_count(sec_count),
        .pub_count(pub_count),
        .turn     (st_q.turn),
        .can_take (can_take),
        .pick_pub (pick_pub),
        .sharing  (sharing)
    );

    assign in_ready = can_take;
    assign accept   = in_valid && can_take;
    assign wr_sec   = accept && !pick_pub;
    assign wr_pub   = accept && pick_pub;

    always_comb begin
        st_d = st_q;
        if (accept && sharing)
            st_d.turn = (st_q.turn == TURN_PUB) ? TURN_SEC : TURN_PUB;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.turn <= TURN_PUB;
        else     st_q      <= st_d;
    end

    rng_word_fifo #(
        .DEPTH(SEC_DEPTH),
        .WIDTH(WORD_W)
    ) u_sec_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_sec),
        .wr_data (in_data),
        .rd_req  (sec_req),
        .rd_valid(sec_valid),
        .rd_data (sec_data),
        .count   (sec_count)
    );

    rng_word_fifo #(
        .DEPTH(PUB_DEPTH),
        .WIDTH(WORD_W)
    ) u_pub_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_pub),
        .wr_data (in_data),
        .rd_req  (pub_req),
        .rd_valid(pub_valid),
        .rd_data (pub_data),
        .count   (pub_count)
    );
endmodule

// File: rtl/rng_secure_split_chk.sv
module rng_secure_split_chk #(
    parameter int SEC_DEPTH = 8,
    parameter int PUB_DEPTH = 4,
    localparam int SEC_CNT_W = $clog2(SEC_DEPTH + 1),
    localparam int PUB_CNT_W = $clog2(PUB_DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 sec_req,
    input logic                 sec_valid,
    input logic [SEC_CNT_W-1:0] sec_count,
    input logic                 pub_req,
    input logic                 pub_valid,
    input logic [PUB_CNT_W-1:0] pub_count,
    input logic                 wr_sec,
    input logic                 wr_pub
);
    localparam logic [SEC_CNT_W-1:0] SEC_HALF_C = SEC_CNT_W'(SEC_DEPTH / 2);
    localparam logic [SEC_CNT_W-1:0] SEC_FULL_C = SEC_CNT_W'(SEC_DEPTH);
    localparam logic [PUB_CNT_W-1:0] PUB_FULL_C = PUB_CNT_W'(PUB_DEPTH);

    // R2
    low_sec_refill_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && sec_count < SEC_HALF_C) |-> (wr_sec && !wr_pub));

    // R3
    pub_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pub |-> (sec_count >= SEC_HALF_C));

    // R6
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_count == SEC_FULL_C && pub_count == PUB_FULL_C) |-> !in_ready);

    // R7
    single_dest_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_sec && wr_pub));

    // R8
    sec_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_req && sec_count == '0 && !wr_sec) |=> (!sec_valid && sec_count == '0));

    // R8
    pub_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (pub_req && pub_count == '0 && !wr_pub) |=> (!pub_valid && pub_count == '0));

    // R9
    sec_pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_req && sec_count != '0 && !wr_sec) |=> (sec_valid && sec_count == $past(sec_count) - 1'b1));

    // R10
    sec_rw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_req && sec_count != '0 && wr_sec) |=> (sec_valid && $stable(sec_count)));

    // R10
    pub_rw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pub_req && pub_count != '0 && wr_pub) |=> (pub_valid && $stable(pub_count)));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_count <= SEC_FULL_C) && (pub_count <= PUB_FULL_C));
endmodule

bind rng_secure_split rng_secure_split_chk #(
    .SEC_DEPTH(SEC_DEPTH),
    .PUB_DEPTH(PUB_DEPTH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .sec_req  (sec_req),
    .sec_valid(sec_valid),
    .sec_count(sec_count),
    .pub_req  (pub_req),
    .pub_valid(pub_valid),
    .pub_count(pub_count),
    .wr_sec   (wr_sec),
    .wr_pub   (wr_pub)
);

// File: tb/tb_rng_secure_split.sv
module tb_rng_secure_split;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_data;
    logic        in_ready;
    logic        sec_req;
    logic        sec_valid;
    logic [31:0] sec_data;
    logic [3:0]  sec_count;
    logic        pub_req;
    logic        pub_valid;
    logic [31:0] pub_data;
    logic [2:0]  pub_count;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;

    always #10 clk = ~clk;

    rng_secure_split dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .sec_req(sec_req), .sec_valid(sec_valid), .sec_data(sec_data), .sec_count(sec_count),
        .pub_req(pub_req), .pub_valid(pub_valid), .pub_data(pub_data), .pub_count(pub_count)
    );

    function automatic logic [31:0] tag(input int i);
        return 32'hC0DE_0000 + 32'(i);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_counts(input string req, input int es, input int ep);
        chk(sec_count == 4'(es), req, "sec_count", 32'(sec_count), 32'(es));
        chk(pub_count == 3'(ep), req, "pub_count", 32'(pub_count), 32'(ep));
    endtask

    // all primitives start and end at a falling edge
    task automatic push(input int i, input string req, input int es, input int ep);
        in_valid = 1'b1;
        in_data  = tag(i);
        chk(in_ready == 1'b1, req, "in_ready before push", 32'(in_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk_counts(req, es, ep);
    endtask

    task automatic pop(input bit side_pub, input int i, input string req, input int es, input int ep);
        if (side_pub) pub_req = 1'b1;
        else          sec_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pub_req = 1'b0;
        sec_req = 1'b0;
        if (side_pub) begin
            chk(pub_valid == 1'b1, req, "pub_valid", 32'(pub_valid), 32'd1);
            chk(pub_data == tag(i), req, "pub_data", pub_data, tag(i));
        end else begin
            chk(sec_valid == 1'b1, req, "sec_valid", 32'(sec_valid), 32'd1);
            chk(sec_data == tag(i), req, "sec_data", sec_data, tag(i));
        end
        chk_counts(req, es, ep);
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        in_valid = 1'b0; in_data = '0; sec_req = 1'b0; pub_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        apply_reset();
        chk_counts("R1", 0, 0);
        chk(sec_valid == 1'b0, "R1", "sec_valid", 32'(sec_valid), 32'd0);
        chk(pub_valid == 1'b0, "R1", "pub_valid", 32'(pub_valid), 32'd0);
        chk(in_ready == 1'b1, "R1", "in_ready", 32'(in_ready), 32'd1);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 4; i++) push(i, "R2", i + 1, 0);
        push(4, "R4", 4, 1);   // first shared word goes to the shared side (R3 gate met)
        push(5, "R4", 5, 1);
        push(6, "R4", 5, 2);
        push(7, "R4", 6, 2);
        push(8, "R4", 6, 3);
        push(9, "R7", 7, 3);
        push(10, "R3", 7, 4);
        push(11, "R5", 8, 4);  // shared full: protected takes it
    endtask

    task automatic t_full_stall();
        in_valid = 1'b1;
        in_data  = tag(99);
        chk(in_ready == 1'b0, "R6", "in_ready when both full", 32'(in_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk_counts("R6", 8, 4);
    endtask

    task automatic t_drain_pub();
        pop(1'b1, 4, "R9", 8, 3);
        pop(1'b1, 6, "R9", 8, 2);
        pop(1'b1, 8, "R9", 8, 1);
        pop(1'b1, 10, "R9", 8, 0);
    endtask

    task automatic t_empty_read();
        pub_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pub_req = 1'b0;
        chk(pub_valid == 1'b0, "R8", "pub_valid on empty read", 32'(pub_valid), 32'd0);
        chk_counts("R8", 8, 0);
    endtask

    task automatic t_sec_full_to_pub();
        push(12, "R5", 8, 1);
    endtask

    task automatic t_drain_sec();
        pop(1'b0, 0, "R9", 7, 1);
        pop(1'b0, 1, "R9", 6, 1);
        pop(1'b0, 2, "R9", 5, 1);
        pop(1'b0, 3, "R9", 4, 1);
        pop(1'b0, 5, "R7", 3, 1);
        pop(1'b0, 7, "R7", 2, 1);
        pop(1'b0, 9, "R7", 1, 1);
        pop(1'b0, 11, "R7", 0, 1);
        sec_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sec_req = 1'b0;
        chk(sec_valid == 1'b0, "R8", "sec_valid on empty read", 32'(sec_valid), 32'd0);
        chk_counts("R8", 0, 1);
    endtask

    task automatic t_low_refill();
        push(13, "R2", 1, 1);
    endtask

    task automatic t_same_cycle();
        in_valid = 1'b1;
        in_data  = tag(14);
        sec_req  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        sec_req  = 1'b0;
        chk(sec_valid == 1'b1, "R10", "sec_valid", 32'(sec_valid), 32'd1);
        chk(sec_data == tag(13), "R10", "sec_data", sec_data, tag(13));
        chk_counts("R10", 1, 1);
        pop(1'b0, 14, "R10", 0, 1);
        pop(1'b1, 12, "R9", 0, 0);
    endtask

    task automatic t_mid_reset();
        push(15, "R11", 1, 0);
        push(16, "R11", 2, 0);
        apply_reset();
        chk_counts("R11", 0, 0);
        chk(in_ready == 1'b1, "R11", "in_ready", 32'(in_ready), 32'd1);
        for (int i = 20; i < 24; i++) push(i, "R11", i - 19, 0);
        push(24, "R11", 4, 1);
        pop(1'b0, 20, "R11", 3, 1);
        pop(1'b1, 24, "R11", 3, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog all-requirements actual=%0d expected<20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_fill();
        t_full_stall();
        t_drain_pub();
        t_empty_read();
        t_sec_full_to_pub();
        t_drain_sec();
        t_low_refill();
        t_same_cycle();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule